// File: doc/BRIEF.md
# Robbed-Bit Signaling Capture Bank

The block collects the robbed signaling bits of the 24 voice channels on a T1/J1 receive path and presents them to a host as twelve 8-bit registers. An upstream framer hands over one signaling bit at a time. Each bit comes with its channel number and its frame number inside the 24-frame collection period. A format input selects between four-bit (A/B/C/D per channel, extended superframe) and two-bit (A/B per 12-frame superframe, two superframes per image) signaling.

Incoming bits first land in a hidden shadow image. When the last bit of a period arrives, the shadow is copied into the readable bank. At the same moment the new image is compared register by register with the previous one. A difference raises a sticky interrupt, and the differing registers are marked in a change mask that accumulates until the host clears it. The host must fetch the image before the next period overwrites it, which leaves roughly 3 ms. Register reads are refused while serial signaling output toward the system side is enabled.

Top module: `rbs_capture`

## Requirements
- R1: With `fmt_f12`=0, frames 6, 12, 18 and 24 carry the A, B, C and D bit of each channel c (1..24). Image position p=(c-1)*4+letter (A=0..D=3) lands in register p/8+1 at bit 7-(p mod 8). Channel 1 A is therefore register 1 bit 7, and channel 24 D is register 12 bit 0.
- R2: With `fmt_f12`=1, frames 6 and 12 carry the A and B bits of the first superframe, and frames 18 and 24 carry those of the second. Position p=s*48+(c-1)*2+b, with s=0 or 1 for the superframe and b=0 for A, 1 for B, is mapped to a register and bit as in R1. Registers 1–6 hold the first superframe and registers 7–12 the second.
- R3: Bits offered in any other frame number, or with a channel outside 1..24, leave the image unchanged.
- R4: The readable bank changes only when the bit of channel 24, frame 24 is accepted. The new image is visible from the following cycle, and a partially collected period is never readable.
- R5: At a boundary where one or more registers differ from the previous image, `irq_changed` is 1 from the next cycle on. Bit n-1 of `chg_ptr` is set for each differing register n. Mask bits accumulate over later periods until cleared.
- R6: A boundary whose image equals the previous one sets neither `irq_changed` nor any `chg_ptr` bit.
- R7: The first boundary after reset, and the first after any change of `fmt_f12`, raises no interrupt and sets no mask bit.
- R8: A `stat_rd` pulse clears `irq_changed` and `chg_ptr` on the next cycle. When it coincides with a boundary that finds differences, the flag stays set and the mask holds only that boundary's differences.
- R9: `rd_data` shows register `rd_addr`+1 combinationally. While `ser_en`=1, or when `rd_addr`>11, `rd_err`=1 and `rd_data`=0.
- R10: After reset, `irq_changed`=0 and `chg_ptr`=0. The bank contents are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_f12 | input | 1 | 0: four-bit signaling, 1: two-bit signaling over two superframes |
| sig_valid | input | 1 | A signaling bit is offered this cycle |
| sig_bit | input | 1 | Signaling bit value |
| sig_chan | input | 5 | Channel number, 1..24 |
| sig_frame | input | 5 | Frame number in the period, 1..24 |
| ser_en | input | 1 | Serial signaling output enabled; blocks register reads |
| rd_addr | input | 4 | Register select, 0..11 for registers 1..12 |
| rd_data | output | 8 | Selected register contents |
| rd_err | output | 1 | Read refused |
| stat_rd | input | 1 | Host status read; clears flag and mask |
| irq_changed | output | 1 | Sticky signaling-changed interrupt |
| chg_ptr | output | 12 | Mask of registers that changed |

## Verification
The bench builds the block with its default of 24 channels, so the full 96-bit image and both corner bits (register 1 bit 7, register 12 bit 0) are reachable under both formats. Directed periods repeat an image, alter single registers, and switch format. Further cases decoy in an unused frame, clear status on the boundary cycle, and read while collection is half done.

// File: rtl/rbs_capture.sv
module rbs_capture #(
  parameter int NCH = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fmt_f12,
  input  logic                         sig_valid,
  input  logic                         sig_bit,
  input  logic [4:0]                   sig_chan,
  input  logic [4:0]                   sig_frame,
  input  logic                         ser_en,
  input  logic [$clog2(NCH/2)-1:0]     rd_addr,
  output logic [7:0]                   rd_data,
  output logic                         rd_err,
  input  logic                         stat_rd,
  output logic                         irq_changed,
  output logic [NCH/2-1:0]             chg_ptr
);
  localparam int IMG  = NCH * 4;
  localparam int NREG = IMG / 8;
  localparam int PW   = $clog2(IMG);
  localparam int AW   = $clog2(NREG);

  logic [IMG-1:0]  shadow, shadow_nxt, bank;
  logic [PW-1:0]   cm1, pos;
  logic            hit, boundary, primed, fmt_q;
  logic [NREG-1:0] mask;
  logic [7:0]      regv [2**AW];

  assign cm1 = PW'(sig_chan) - PW'(1);

  always_comb begin
    hit = 1'b0;
    pos = '0;
    if (sig_valid && sig_chan >= 5'd1 && sig_chan <= 5'(NCH)) begin
      case (sig_frame)
        5'd6:  begin hit = 1'b1; pos = fmt_f12 ? cm1 * PW'(2) : cm1 * PW'(4); end
        5'd12: begin hit = 1'b1; pos = fmt_f12 ? cm1 * PW'(2) + PW'(1) : cm1 * PW'(4) + PW'(1); end
        5'd18: begin hit = 1'b1; pos = fmt_f12 ? PW'(IMG/2) + cm1 * PW'(2) : cm1 * PW'(4) + PW'(2); end
        5'd24: begin hit = 1'b1; pos = fmt_f12 ? PW'(IMG/2) + cm1 * PW'(2) + PW'(1) : cm1 * PW'(4) + PW'(3); end
        default: ;
      endcase
    end
    shadow_nxt = shadow;
    if (hit) shadow_nxt[PW'(IMG-1) - pos] = sig_bit;
  end

  assign boundary = hit && sig_chan == 5'(NCH) && sig_frame == 5'd24;

  for (genvar r = 0; r < 2**AW; r++) begin : g_reg
    if (r < NREG) begin : g_live
      assign regv[r]  = bank[IMG-8*(r+1) +: 8];
      assign mask[r]  = |(shadow_nxt[IMG-8*(r+1) +: 8] ^ bank[IMG-8*(r+1) +: 8]);
    end else begin : g_pad
      assign regv[r]  = 8'h00;
    end
  end

  assign rd_err  = ser_en || (rd_addr >= AW'(NREG));
  assign rd_data = rd_err ? 8'h00 : regv[rd_addr];

  always_ff @(posedge clk) begin
    shadow <= shadow_nxt;
    if (boundary) bank <= shadow_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_changed <= 1'b0;
      chg_ptr     <= '0;
      primed      <= 1'b0;
      fmt_q       <= 1'b0;
    end else begin
      fmt_q <= fmt_f12;
      if (stat_rd) begin
        irq_changed <= 1'b0;
        chg_ptr     <= '0;
      end
      if (boundary && primed && |mask) begin
        irq_changed <= 1'b1;
        chg_ptr     <= (stat_rd ? '0 : chg_ptr) | mask;
      end
      if (fmt_f12 != fmt_q) primed <= 1'b0;
      else if (boundary)    primed <= 1'b1;
    end
  end

  assert_bank_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!boundary && !stat_rd) |=> ($stable(irq_changed) && $stable(chg_ptr)));

  assert_ptr_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_ptr != '0) |-> irq_changed);

  assert_first_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !primed && !stat_rd) |=> $stable(irq_changed));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !boundary) |=> (!irq_changed && chg_ptr == '0));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (rd_err && rd_data == 8'h00));
endmodule

// File: tb/rbs_capture_tb.sv
module rbs_capture_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, fmt_f12, sig_valid, sig_bit, ser_en, stat_rd, rd_err, irq_changed;
  logic [4:0]  sig_chan, sig_frame;
  logic [3:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [11:0] chg_ptr;
  int checks = 0, errors = 0;

  rbs_capture u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_f12(fmt_f12), .sig_valid(sig_valid), .sig_bit(sig_bit),
    .sig_chan(sig_chan), .sig_frame(sig_frame), .ser_en(ser_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_err(rd_err), .stat_rd(stat_rd), .irq_changed(irq_changed),
    .chg_ptr(chg_ptr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit map_bit(input logic [95:0] img, input bit f12, input int c, input int f);
    int p;
    if (!f12) p = (c - 1) * 4 + f / 6 - 1;
    else      p = (f > 12 ? 48 : 0) + (c - 1) * 2 + ((f % 12 == 0) ? 1 : 0);
    return img[95 - p];
  endfunction

  task automatic check_regs(input logic [95:0] img, input string req);
    for (int n = 1; n <= 12; n++) begin
      rd_addr = 4'(n - 1);
      #1;
      chk(rd_data === img[(12 - n) * 8 +: 8] && !rd_err, req, {23'd0, rd_err, rd_data}, {24'd0, img[(12 - n) * 8 +: 8]});
    end
  endtask

  task automatic send_mf(input logic [95:0] img, input bit mid_chk, input logic [95:0] prev, input bit clr_last);
    for (int f = 1; f <= 24; f++) begin
      for (int c = 1; c <= 24; c++) begin
        if (f % 6 == 0 || f == 3) begin
          @(negedge clk);
          sig_valid = 1'b1;
          sig_chan  = 5'(c);
          sig_frame = 5'(f);
          sig_bit   = (f == 3) ? ~map_bit(img, fmt_f12, c, 6) : map_bit(img, fmt_f12, c, f);
          stat_rd   = clr_last && f == 24 && c == 24;
        end
      end
      if (mid_chk && f == 12) begin
        @(negedge clk);
        sig_valid = 1'b0;
        check_regs(prev, "R4 partial period hidden");
      end
    end
    @(negedge clk);
    sig_valid = 1'b0;
    stat_rd   = 1'b0;
  endtask

  task automatic pulse_stat;
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk(irq_changed === 1'b0, "R10 flag after reset", {31'd0, irq_changed}, 0);
    chk(chg_ptr === 12'h000, "R10 mask after reset", {20'd0, chg_ptr}, 0);
  endtask

  localparam logic [95:0] IMG_A = 96'h0123_4567_89AB_CDEF_FEDC_BA98;
  localparam logic [95:0] IMG_B = IMG_A ^ (96'hFF << 80) ^ 96'h01;
  localparam logic [95:0] IMG_C = IMG_B ^ (96'h10 << 56);
  localparam logic [95:0] IMG_D = IMG_C ^ (96'h01 << 88);
  localparam logic [95:0] IMG_E = 96'hA5C3_0F96_5A3C_F069_1248_8421;
  localparam logic [95:0] IMG_F = IMG_E ^ (96'h03 << 40);

  task automatic t_esf_first;
    send_mf(IMG_A, 1'b0, '0, 1'b0);
    chk(irq_changed === 1'b0, "R7 first period after reset", {31'd0, irq_changed}, 0);
    check_regs(IMG_A, "R1/R3 four-bit mapping");
  endtask

  task automatic t_esf_same;
    send_mf(IMG_A, 1'b1, IMG_A, 1'b0);
    chk(irq_changed === 1'b0, "R6 repeated image", {31'd0, irq_changed}, 0);
    chk(chg_ptr === 12'h000, "R6 repeated image mask", {20'd0, chg_ptr}, 0);
  endtask

  task automatic t_esf_change;
    send_mf(IMG_B, 1'b1, IMG_A, 1'b0);
    chk(irq_changed === 1'b1, "R5 change flag", {31'd0, irq_changed}, 1);
    chk(chg_ptr === 12'h802, "R5 change mask", {20'd0, chg_ptr}, 32'h802);
    check_regs(IMG_B, "R4 new image visible");
    send_mf(IMG_C, 1'b0, '0, 1'b0);
    chk(chg_ptr === 12'h812, "R5 mask accumulates", {20'd0, chg_ptr}, 32'h812);
  endtask

  task automatic t_clear;
    pulse_stat();
    chk(irq_changed === 1'b0, "R8 clear flag", {31'd0, irq_changed}, 0);
    chk(chg_ptr === 12'h000, "R8 clear mask", {20'd0, chg_ptr}, 0);
    send_mf(IMG_D, 1'b0, '0, 1'b1);
    chk(irq_changed === 1'b1, "R8 boundary wins over clear", {31'd0, irq_changed}, 1);
    chk(chg_ptr === 12'h001, "R8 mask holds only new change", {20'd0, chg_ptr}, 1);
    pulse_stat();
  endtask

  task automatic t_f12;
    @(negedge clk); fmt_f12 = 1'b1;
    repeat (2) @(negedge clk);
    send_mf(IMG_E, 1'b0, '0, 1'b0);
    chk(irq_changed === 1'b0, "R7 first period after format change", {31'd0, irq_changed}, 0);
    check_regs(IMG_E, "R2 two-bit mapping");
    send_mf(IMG_E, 1'b0, '0, 1'b0);
    chk(irq_changed === 1'b0, "R6 repeated two-bit image", {31'd0, irq_changed}, 0);
    send_mf(IMG_F, 1'b0, '0, 1'b0);
    chk(irq_changed === 1'b1, "R5 two-bit change flag", {31'd0, irq_changed}, 1);
    chk(chg_ptr === 12'h040, "R2 second superframe in register 7", {20'd0, chg_ptr}, 32'h040);
  endtask

  task automatic t_gate;
    @(negedge clk); ser_en = 1'b1; rd_addr = 4'd6; #1;
    chk(rd_err === 1'b1 && rd_data === 8'h00, "R9 read blocked", {23'd0, rd_err, rd_data}, 32'h100);
    @(negedge clk); ser_en = 1'b0; rd_addr = 4'd12; #1;
    chk(rd_err === 1'b1 && rd_data === 8'h00, "R9 address out of range", {23'd0, rd_err, rd_data}, 32'h100);
    rd_addr = 4'd11; #1;
    chk(rd_err === 1'b0 && rd_data === IMG_F[7:0], "R9 read allowed", {23'd0, rd_err, rd_data}, {24'd0, IMG_F[7:0]});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fmt_f12 = 1'b0; sig_valid = 1'b0; sig_bit = 1'b0; sig_chan = 5'd0;
    sig_frame = 5'd0; ser_en = 1'b0; stat_rd = 1'b0; rd_addr = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_esf_first();
    t_esf_same();
    t_esf_change();
    t_clear();
    t_f12();
    t_gate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule